// File: doc/BRIEF.md
# Per-CPU Interrupt Wakeup Generator

This always-on block sits beside a generic interrupt controller and watches the shared peripheral interrupt lines. Every line is forwarded unchanged to the controller. While a CPU reports that it is in a low-power state, the block raises a wakeup request for that CPU as soon as an interrupt arrives whose wakeup enable is set.

Each CPU owns its own bank of 32-bit enable registers. One bit in these registers belongs to each shared interrupt. Software reaches the registers through a single-cycle register port. A mode register picks one of two policies. In the joint policy, all cores leave OFF together: any enabled pending interrupt wakes every sleeping CPU. In the independent policy, each CPU is woken only through its own enable bank.

Top module: `wkg_top`

## Requirements
- R1: After reset every enable bit of every CPU reads 0, the mode register reads 0 and every wake output is 0.
- R2: The enable register for bank b of CPU c sits at byte address c*0x400 + b*4 and reads back the full 32-bit value last written.
- R3: Shared interrupt n is controlled by bit (n mod 32) of bank (n >> 5).
- R4: The forward output equals the interrupt input in the same cycle, whatever the enables, the mode or the low-power flags.
- R5: A CPU whose low-power flag is 0 never has its wake output set.
- R6: In independent mode, an interrupt whose enable bit is clear for a CPU never wakes that CPU.
- R7: In independent mode (mode bit 5 = 1), a sleeping CPU wakes only for pending interrupts enabled in its own bank.
- R8: In joint mode (mode bit 5 = 0), a pending interrupt enabled in any CPU's bank wakes every CPU whose low-power flag is 1.
- R9: The mode register sits at byte address NUM_CPUS*0x400 (0x800 by default). Only bit 5 is stored, and all other bits read 0.
- R10: A read of an unmapped or misaligned address returns 0, and a write to one changes no register.
- R11: The wake outputs are registered. They reflect the inputs sampled at the previous rising clock edge.
- R12: Writing all zeros to a bank masks all 32 of its interrupts for that CPU. Writing all ones enables them all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_in | input | NUM_BANKS*32 | Shared peripheral interrupt lines |
| cpu_lowpwr | input | NUM_CPUS | Per-CPU low-power flag |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_fwd | output | NUM_BANKS*32 | Interrupts forwarded to the controller |
| cpu_wake | output | NUM_CPUS | Per-CPU wakeup request |

## Verification
The case that is hardest to reach from the ports is the split between the two policies. The same interrupt with the same enable contents must wake both CPUs in one mode and only one CPU in the other. To get there, the bench gives the two CPUs disjoint enable patterns and holds both in low power. It then flips only the mode register and replays an identical interrupt. The bank edges (interrupts 0, 31, 32 and the last one) are driven one by one, each with a neighbouring line as a negative case, to pin down the index and bit mapping.

// File: rtl/wkg_pkg.sv
package wkg_pkg;
    localparam int WORD_W      = 32;
    localparam int CPU_STRIDE  = 1024;
    localparam int STRIDE_LSB  = 10;
    localparam int MODE_BIT    = 5;
endpackage

// File: rtl/wkg_addr_dec.sv
module wkg_addr_dec
    import wkg_pkg::*;
#(
    parameter int NUM_CPUS  = 2,
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 12,
    parameter int CPU_W     = 1,
    parameter int BANK_W    = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_en,
    output logic              sel_mode,
    output logic [CPU_W-1:0]  cpu_idx,
    output logic [BANK_W-1:0] bank_idx
);
    localparam int REGION_W = ADDR_W - STRIDE_LSB;
    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_CPUS * CPU_STRIDE);

    logic [REGION_W-1:0] region;
    logic [7:0]          word;
    logic                aligned;

    always_comb begin
        region   = addr[ADDR_W-1:STRIDE_LSB];
        word     = addr[STRIDE_LSB-1:2];
        aligned  = (addr[1:0] == 2'b00);
        sel_en   = aligned && (region < REGION_W'(NUM_CPUS)) && (word < 8'(NUM_BANKS));
        sel_mode = (addr == MODE_ADDR);
        cpu_idx  = region[CPU_W-1:0];
        bank_idx = word[BANK_W-1:0];
    end
endmodule

// File: rtl/wkg_regbank.sv
module wkg_regbank
    import wkg_pkg::*;
#(
    parameter int NUM_CPUS  = 2,
    parameter int NUM_BANKS = 5,
    parameter int CPU_W     = 1,
    parameter int BANK_W    = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we,
    input  logic                                 sel_en,
    input  logic                                 sel_mode,
    input  logic [CPU_W-1:0]                     cpu_idx,
    input  logic [BANK_W-1:0]                    bank_idx,
    input  logic [WORD_W-1:0]                    wdata,
    output logic [WORD_W-1:0]                    rdata,
    output logic [NUM_CPUS*NUM_BANKS*WORD_W-1:0] en_flat,
    output logic                                 indep
);
    localparam int NREG  = NUM_CPUS * NUM_BANKS;
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    typedef struct packed {
        logic [NREG-1:0][WORD_W-1:0] en;
        logic                        indep;
    } state_t;

    state_t           state_d, state_q;
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx     = IDX_W'(int'(cpu_idx) * NUM_BANKS + int'(bank_idx));
        state_d = state_q;
        if (we && sel_en) begin
            state_d.en[idx] = wdata;
        end
        if (we && sel_mode) begin
            state_d.indep = wdata[MODE_BIT];
        end
        if (sel_en) begin
            rdata = state_q.en[idx];
        end else if (sel_mode) begin
            rdata = WORD_W'(state_q.indep) << MODE_BIT;
        end else begin
            rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign en_flat = state_q.en;
    assign indep   = state_q.indep;
endmodule

// File: rtl/wkg_wake_eval.sv
module wkg_wake_eval #(
    parameter int NUM_CPUS = 2,
    parameter int NUM_IRQ  = 160
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_IRQ-1:0]          irq,
    input  logic [NUM_CPUS-1:0]         lowpwr,
    input  logic [NUM_CPUS*NUM_IRQ-1:0] en_flat,
    input  logic                        indep,
    output logic [NUM_CPUS-1:0]         wake
);
    typedef struct packed {
        logic [NUM_CPUS-1:0] wake;
    } state_t;

    state_t              state_d, state_q;
    logic [NUM_CPUS-1:0] hit;
    logic                any_hit;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_hit
        assign hit[c] = |(irq & en_flat[c*NUM_IRQ +: NUM_IRQ]);
    end

    always_comb begin
        any_hit = |hit;
        state_d = state_q;
        for (int c = 0; c < NUM_CPUS; c++) begin
            state_d.wake[c] = lowpwr[c] & (indep ? hit[c] : any_hit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign wake = state_q.wake;
endmodule

// File: rtl/wkg_top.sv
module wkg_top
    import wkg_pkg::*;
#(
    parameter int NUM_CPUS  = 2,
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*WORD_W-1:0] spi_in,
    input  logic [NUM_CPUS-1:0]         cpu_lowpwr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic                        reg_we,
    input  logic [WORD_W-1:0]           reg_wdata,
    output logic [WORD_W-1:0]           reg_rdata,
    output logic [NUM_BANKS*WORD_W-1:0] irq_fwd,
    output logic [NUM_CPUS-1:0]         cpu_wake
);
    localparam int NUM_IRQ = NUM_BANKS * WORD_W;
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
    localparam int BANK_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic                        sel_en;
    logic                        sel_mode;
    logic [CPU_W-1:0]            cpu_idx;
    logic [BANK_W-1:0]           bank_idx;
    logic [NUM_CPUS*NUM_IRQ-1:0] en_flat;
    logic                        indep_mode;

    wkg_addr_dec #(
        .NUM_CPUS (NUM_CPUS),
        .NUM_BANKS(NUM_BANKS),
        .ADDR_W   (ADDR_W),
        .CPU_W    (CPU_W),
        .BANK_W   (BANK_W)
    ) u_dec (
        .addr    (reg_addr),
        .sel_en  (sel_en),
        .sel_mode(sel_mode),
        .cpu_idx (cpu_idx),
        .bank_idx(bank_idx)
    );

    wkg_regbank #(
        .NUM_CPUS (NUM_CPUS),
        .NUM_BANKS(NUM_BANKS),
        .CPU_W    (CPU_W),
        .BANK_W   (BANK_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .sel_en  (sel_en),
        .sel_mode(sel_mode),
        .cpu_idx (cpu_idx),
        .bank_idx(bank_idx),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .en_flat (en_flat),
        .indep   (indep_mode)
    );

    wkg_wake_eval #(
        .NUM_CPUS(NUM_CPUS),
        .NUM_IRQ (NUM_IRQ)
    ) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq    (spi_in),
        .lowpwr (cpu_lowpwr),
        .en_flat(en_flat),
        .indep  (indep_mode),
        .wake   (cpu_wake)
    );

    // Interrupts bypass the wakeup gating entirely on their way to the controller.
    assign irq_fwd = spi_in;
endmodule

// File: rtl/wkg_checker.sv
module wkg_checker #(
    parameter int NUM_CPUS  = 2,
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 12
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_BANKS*32-1:0]          spi_in,
    input logic [NUM_CPUS-1:0]              cpu_lowpwr,
    input logic [ADDR_W-1:0]                reg_addr,
    input logic                             reg_we,
    input logic [31:0]                      reg_wdata,
    input logic [NUM_CPUS-1:0]              cpu_wake,
    input logic [NUM_CPUS*NUM_BANKS*32-1:0] en_flat,
    input logic                             indep_mode
);
    localparam int NUM_IRQ = NUM_BANKS * 32;

    logic [NUM_CPUS-1:0] chk_hit;
    logic                chk_any;

    always_comb begin
        for (int c = 0; c < NUM_CPUS; c++) begin
            chk_hit[c] = |(spi_in & en_flat[c*NUM_IRQ +: NUM_IRQ]);
        end
        chk_any = |chk_hit;
    end

    p_mode_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(NUM_CPUS * 1024)) |=> (indep_mode == $past(reg_wdata[5])));

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        p_awake_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !cpu_lowpwr[c] |=> !cpu_wake[c]);

        p_own_hit_wakes_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_lowpwr[c] && chk_hit[c]) |=> cpu_wake[c]);

        p_indep_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (indep_mode && !chk_hit[c]) |=> !cpu_wake[c]);

        p_joint_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!indep_mode && cpu_lowpwr[c] && chk_any) |=> cpu_wake[c]);
    end
endmodule

bind wkg_top wkg_checker #(
    .NUM_CPUS (NUM_CPUS),
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W)
) u_wkg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_in    (spi_in),
    .cpu_lowpwr(cpu_lowpwr),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .cpu_wake  (cpu_wake),
    .en_flat   (en_flat),
    .indep_mode(indep_mode)
);

// File: tb/tb_wkg_top.sv
`timescale 1ns/1ps
module tb_wkg_top;
    localparam int NC = 2;
    localparam int NB = 5;
    localparam int NI = NB * 32;
    localparam int AW = 12;
    localparam logic [AW-1:0] MODE_A = 12'h800;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] spi_in = '0;
    logic [NC-1:0] cpu_lowpwr = '0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NI-1:0] irq_fwd;
    logic [NC-1:0] cpu_wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wkg_top #(.NUM_CPUS(NC), .NUM_BANKS(NB), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .spi_in(spi_in), .cpu_lowpwr(cpu_lowpwr),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_fwd(irq_fwd), .cpu_wake(cpu_wake)
    );

    task automatic chk(input bit ok, input string tag, input logic [NI-1:0] act, input logic [NI-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a; #1;
        chk(reg_rdata == exp, tag, NI'(reg_rdata), NI'(exp));
    endtask

    function automatic logic [AW-1:0] en_addr(input int cpu, input int n);
        return AW'(cpu * 1024 + (n >> 5) * 4);
    endfunction

    // Drive interrupt and low-power inputs, then look at the wake outputs one edge later.
    task automatic drive_wake(input logic [NI-1:0] s, input logic [NC-1:0] lp, input logic [NC-1:0] exp, input string tag);
        @(negedge clk);
        spi_in = s; cpu_lowpwr = lp;
        @(posedge clk); #1;
        chk(cpu_wake == exp, tag, NI'(cpu_wake), NI'(exp));
    endtask

    task automatic clear_all();
        for (int c = 0; c < NC; c++)
            for (int b = 0; b < NB; b++)
                wr(AW'(c * 1024 + b * 4), 32'h0);
        @(negedge clk);
        spi_in = '0; cpu_lowpwr = '0;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        rd_chk(12'h000, 32'h0, "R1 cpu0 bank0 reset");
        rd_chk(12'h410, 32'h0, "R1 cpu1 bank4 reset");
        rd_chk(MODE_A, 32'h0, "R1 mode reset");
        chk(cpu_wake == '0, "R1 wake reset", NI'(cpu_wake), '0);
    endtask

    task automatic t_addr_map();
        for (int c = 0; c < NC; c++)
            for (int b = 0; b < NB; b++)
                wr(AW'(c * 1024 + b * 4), 32'hA500_0000 ^ (c << 16) ^ b);
        for (int c = 0; c < NC; c++)
            for (int b = 0; b < NB; b++)
                rd_chk(AW'(c * 1024 + b * 4), 32'hA500_0000 ^ (c << 16) ^ b, "R2 bank readback");
        clear_all();
    endtask

    task automatic t_bit_map();
        int ids[4] = '{0, 31, 32, NI - 1};
        wr(MODE_A, 32'h20);
        foreach (ids[i]) begin
            int n = ids[i];
            int other = (n == NI - 1) ? n - 1 : n + 1;
            wr(en_addr(0, n), 32'(1) << (n % 32));
            drive_wake(NI'(1) << other, 2'b01, 2'b00, "R3 neighbour line ignored");
            drive_wake(NI'(1) << n, 2'b01, 2'b01, "R3 mapped line wakes");
            wr(en_addr(0, n), 32'h0);
        end
        clear_all();
        wr(MODE_A, 32'h0);
    endtask

    task automatic t_passthrough();
        logic [NI-1:0] pats[3];
        pats[0] = {NB{32'hDEAD_BEEF}};
        pats[1] = NI'(1) << (NI - 1);
        pats[2] = {NB{32'h0F0F_1234}};
        wr(en_addr(1, 5), 32'hFFFF_FFFF);
        foreach (pats[i]) begin
            @(negedge clk);
            spi_in = pats[i]; cpu_lowpwr = 2'(i);
            #1;
            chk(irq_fwd == pats[i], "R4 forward unchanged", irq_fwd, pats[i]);
        end
        clear_all();
    endtask

    task automatic t_awake();
        wr(MODE_A, 32'h20);
        wr(en_addr(1, 66), 32'hFFFF_FFFF);
        drive_wake(NI'(1) << 66, 2'b00, 2'b00, "R5 awake cpu stays quiet");
        drive_wake(NI'(1) << 66, 2'b10, 2'b10, "R5 sleeping cpu wakes");
        clear_all();
        wr(MODE_A, 32'h0);
    endtask

    task automatic t_mask_all();
        wr(MODE_A, 32'h20);
        wr(12'h008, 32'hFFFF_FFFF);
        drive_wake(NI'(1) << 70, 2'b01, 2'b01, "R12 all-ones unmasks");
        drive_wake(NI'(1) << 95, 2'b01, 2'b01, "R12 all-ones unmasks top bit");
        wr(12'h008, 32'h0);
        drive_wake(NI'(1) << 70, 2'b01, 2'b00, "R6 R12 all-zero masks");
        clear_all();
        wr(MODE_A, 32'h0);
    endtask

    task automatic t_policies();
        wr(en_addr(0, 10), 32'(1) << 10);
        wr(en_addr(1, 100), 32'(1) << (100 % 32));
        wr(MODE_A, 32'h20);
        drive_wake(NI'(1) << 10, 2'b11, 2'b01, "R7 indep own bank cpu0");
        drive_wake(NI'(1) << 100, 2'b11, 2'b10, "R7 indep own bank cpu1");
        wr(MODE_A, 32'h0);
        drive_wake(NI'(1) << 10, 2'b11, 2'b11, "R8 joint wakes all");
        drive_wake(NI'(1) << 100, 2'b01, 2'b01, "R8 joint skips awake cpu");
        clear_all();
    endtask

    task automatic t_mode_reg();
        wr(MODE_A, 32'hFFFF_FFFF);
        rd_chk(MODE_A, 32'h20, "R9 only bit5 kept");
        wr(MODE_A, 32'hFFFF_FFDF);
        rd_chk(MODE_A, 32'h0, "R9 bit5 cleared");
    endtask

    task automatic t_unmapped();
        wr(12'h000, 32'h1234_5678);
        wr(12'h014, 32'hFFFF_FFFF);
        wr(12'h001, 32'hFFFF_FFFF);
        wr(12'hC00, 32'hFFFF_FFFF);
        wr(12'h3FC, 32'hFFFF_FFFF);
        rd_chk(12'h014, 32'h0, "R10 bank past end reads 0");
        rd_chk(12'h001, 32'h0, "R10 misaligned reads 0");
        rd_chk(12'hC00, 32'h0, "R10 past cpus reads 0");
        rd_chk(12'h000, 32'h1234_5678, "R10 mapped reg untouched");
        rd_chk(MODE_A, 32'h0, "R10 mode untouched");
        for (int b = 1; b < NB; b++) rd_chk(AW'(b * 4), 32'h0, "R10 cpu0 banks untouched");
        for (int b = 0; b < NB; b++) rd_chk(AW'(1024 + b * 4), 32'h0, "R10 cpu1 banks untouched");
        clear_all();
    endtask

    task automatic t_latency();
        wr(MODE_A, 32'h20);
        wr(12'h004, 32'h20);
        drive_wake('0, 2'b01, 2'b00, "R11 idle");
        @(negedge clk);
        spi_in = NI'(1) << 37; #1;
        chk(cpu_wake == 2'b00, "R11 no wake before edge", NI'(cpu_wake), '0);
        @(posedge clk); #1;
        chk(cpu_wake == 2'b01, "R11 wake after one edge", NI'(cpu_wake), NI'(2'b01));
        drive_wake('0, 2'b01, 2'b00, "R11 drops after one edge");
        clear_all();
        wr(MODE_A, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_addr_map();
        t_bit_map();
        t_passthrough();
        t_awake();
        t_mask_all();
        t_policies();
        t_mode_reg();
        t_unmapped();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule